// File: doc/BRIEF.md
# Multi-mode DDR transmit lane demultiplexer

This block sits at the parallel transmit input of a two-channel serial link. Both channels share one 10-bit bus. The bus is sampled on both edges of a transmit clock. In each transmit-clock period the block rebuilds one word per channel and presents it in the rising-edge domain, together with a K-character flag and a valid strobe. The serial encoder downstream then consumes these words.

A 2-bit mode input sets how the bus is shared:
- **Dedicated mode (0):** one channel owns the whole bus.
- **Interleaved mode (1):** the two channels alternate between the two edges.
- **Half-word mode (2):** the bus is split into two 5-bit lanes. Each lane delivers half of a word on each edge.

A format input chooses the word layout:
- **Low:** raw 10-bit words.
- **High:** an 8-bit byte plus a K flag.

In dedicated mode the capture clock is the channel pair's own transmit clock. In all other modes it is the shared transmit clock. Mode and format are configuration inputs that are expected to stay still. Any change to them voids the next word.

Top module: `tx_ddr_lane_demux`

## Requirements
- R1: While reset is asserted, every word, K flag and valid output is zero. The first three rising edges after reset release also give valid low on both channels.
- R2: In mode 1, channel A takes the bus value sampled on the falling edge. Channel B takes the value sampled on the next rising edge. Both appear after that rising edge.
- R3: In mode 2 with the format input low, channel A's word is {rise[4:0], fall[4:0]} and channel B's word is {rise[9:5], fall[9:5]}. Word bit 0 is the first serial bit and comes from the falling-edge half.
- R4: In mode 0, channel A takes the rising-edge sample. The falling-edge sample has no effect on any output, and channel B's valid stays low.
- R5: With the format input low, the output word holds all 10 captured bits in their positions, and K is 0.
- R6: With the format input high in mode 0 or mode 1, the word is {2'b00, sample[7:0]} and K is sample bit 8. Sample bit 9 has no effect.
- R7: With the format input high in mode 2, bit 3 of each 5-bit half is the K position. K comes from the falling-edge half, and bit 3 of the rising-edge half is ignored. Each half yields the nibble {h[4], h[2:0]}, and the word is {2'b00, high nibble, low nibble}.
- R8: In mode 0 the bus is captured on the edges of the pair clock. In modes 1 to 3 it is captured on the edges of the shared clock.
- R9: If mode or format at a rising edge differs from its value at the previous edge, the word produced on that edge has valid low on both channels. The next word is valid again.
- R10: Outside the cases in R1 and R9, valid is high on every rising edge for each channel the mode drives: A only in mode 0, A and B in modes 1 and 2, neither in mode 3. A channel whose valid is low shows a zero word and K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_common_i | input | 1 | Shared transmit clock |
| clk_pair_i | input | 1 | Transmit clock of this channel pair |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 2 | 0 dedicated, 1 interleaved, 2 half-word, 3 reserved |
| code_i | input | 1 | Format select: 0 raw 10-bit words, 1 byte plus K flag |
| bus_i | input | 10 | Shared DDR transmit bus |
| a_word_o | output | 10 | Channel A word, bit 0 sent first |
| a_k_o | output | 1 | Channel A K-character flag |
| a_valid_o | output | 1 | Channel A word valid |
| b_word_o | output | 10 | Channel B word, bit 0 sent first |
| b_k_o | output | 1 | Channel B K-character flag |
| b_valid_o | output | 1 | Channel B word valid |

## Verification
Two events can land on the same rising edge: a word completing and a configuration change. The bench provokes this by flipping the format input, or by moving between modes 1 and 2, just after an edge. The following edge then both finishes a word and sees the new setting. The expected outcome is that this word comes out with valid low, a zero word and a zero K flag on both channels. The very next period must yield a correct word under the new setting. Word values are judged against a reference model in the bench, fed with random and directed bus patterns.

// File: rtl/tx_ddr_pkg.sv
package tx_ddr_pkg;

  // Number of channels sharing one transmit bus
  localparam int CH_COUNT = 2;

  // Bus sharing modes; the encoding is visible at the mode input
  typedef enum logic [1:0] {
    MODE_INDEP  = 2'd0,
    MODE_MUX    = 2'd1,
    MODE_NIBBLE = 2'd2,
    MODE_RSVD   = 2'd3
  } lane_mode_e;

endpackage

// File: rtl/tx_ddr_clk_rst.sv
// Picks the capture clock for the pair and releases reset synchronously to it.
module tx_ddr_clk_rst #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_common_i,
  input  logic clk_pair_i,
  input  logic sel_pair_i,
  input  logic rst_ni,
  output logic clk_o,
  output logic rst_no
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;

  assign clk_o = sel_pair_i ? clk_pair_i : clk_common_i;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], 1'b1};
  end

  always_ff @(posedge clk_o or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[MSB];

endmodule

// File: rtl/tx_ddr_fall_capture.sv
// Falling-edge half of the DDR input register.
module tx_ddr_fall_capture #(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] cap_q;
  logic [WIDTH-1:0] cap_d;

  always_comb begin
    cap_d = d_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign q_o = cap_q;

endmodule

// File: rtl/tx_ddr_word_unpack.sv
// Maps the falling and rising samples onto per-channel words and K flags.
module tx_ddr_word_unpack
  import tx_ddr_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int DATA_W    = 8,
  parameter int NIB_K_BIT = 3
) (
  input  lane_mode_e                         mode_i,
  input  logic                               code_i,
  input  logic [WORD_W-1:0]                  fall_i,
  input  logic [WORD_W-1:0]                  rise_i,
  output logic [CH_COUNT-1:0][WORD_W-1:0]    word_o,
  output logic [CH_COUNT-1:0]                k_o,
  output logic [CH_COUNT-1:0]                drive_o
);

  localparam int LANE_W  = WORD_W / CH_COUNT;
  localparam int NIB_D_W = LANE_W - 1;
  localparam int PAD_W   = WORD_W - DATA_W;
  localparam int NPAD_W  = WORD_W - 2 * NIB_D_W;

  // Drop the K position from a half-word lane, keeping bit order
  function automatic logic [NIB_D_W-1:0] strip_k(input logic [LANE_W-1:0] lane);
    logic [NIB_D_W-1:0] r;
    for (int i = 0; i < NIB_D_W; i++) begin
      r[i] = (i < NIB_K_BIT) ? lane[i] : lane[i+1];
    end
    return r;
  endfunction

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    localparam bit IS_FIRST = (ch == 0);

    logic [WORD_W-1:0] full_w;
    logic [LANE_W-1:0] lo_w;
    logic [LANE_W-1:0] hi_w;
    logic [WORD_W-1:0] word_l;
    logic              k_l;
    logic              drive_l;

    assign lo_w = fall_i[ch*LANE_W +: LANE_W];
    assign hi_w = rise_i[ch*LANE_W +: LANE_W];

    if (IS_FIRST) begin : g_first
      // Interleaved: first channel rides the falling edge
      assign full_w = (mode_i == MODE_MUX) ? fall_i : rise_i;
    end else begin : g_other
      assign full_w = rise_i;
    end

    always_comb begin
      word_l  = '0;
      k_l     = 1'b0;
      drive_l = 1'b0;
      case (mode_i)
        MODE_INDEP, MODE_MUX: begin
          drive_l = (mode_i == MODE_MUX) || IS_FIRST;
          if (code_i) begin
            word_l = {{PAD_W{1'b0}}, full_w[DATA_W-1:0]};
            k_l    = full_w[DATA_W];
          end else begin
            word_l = full_w;
          end
        end
        MODE_NIBBLE: begin
          drive_l = 1'b1;
          if (code_i) begin
            word_l = {{NPAD_W{1'b0}}, strip_k(hi_w), strip_k(lo_w)};
            k_l    = lo_w[NIB_K_BIT];
          end else begin
            word_l = {hi_w, lo_w};
          end
        end
        default: begin
          drive_l = 1'b0;
        end
      endcase
    end

    assign word_o[ch]  = word_l;
    assign k_o[ch]     = k_l;
    assign drive_o[ch] = drive_l;
  end

endmodule

// File: rtl/tx_ddr_lane_demux.sv
// Top: DDR capture of a shared transmit bus into two per-channel word streams.
module tx_ddr_lane_demux
  import tx_ddr_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int DATA_W      = 8,
  parameter int NIB_K_BIT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_common_i,
  input  logic              clk_pair_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              code_i,
  input  logic [WORD_W-1:0] bus_i,
  output logic [WORD_W-1:0] a_word_o,
  output logic              a_k_o,
  output logic              a_valid_o,
  output logic [WORD_W-1:0] b_word_o,
  output logic              b_k_o,
  output logic              b_valid_o
);

  logic       tx_clk;
  logic       rst_n_sync;
  lane_mode_e mode_w;

  assign mode_w = lane_mode_e'(mode_i);

  tx_ddr_clk_rst #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clk_rst (
    .clk_common_i(clk_common_i),
    .clk_pair_i  (clk_pair_i),
    .sel_pair_i  (mode_w == MODE_INDEP),
    .rst_ni      (rst_ni),
    .clk_o       (tx_clk),
    .rst_no      (rst_n_sync)
  );

  logic [WORD_W-1:0] fall_q;

  tx_ddr_fall_capture #(
    .WIDTH(WORD_W)
  ) u_fall (
    .clk_i (tx_clk),
    .rst_ni(rst_n_sync),
    .d_i   (bus_i),
    .q_o   (fall_q)
  );

  logic [CH_COUNT-1:0][WORD_W-1:0] word_w;
  logic [CH_COUNT-1:0]             k_w;
  logic [CH_COUNT-1:0]             drive_w;

  tx_ddr_word_unpack #(
    .WORD_W   (WORD_W),
    .DATA_W   (DATA_W),
    .NIB_K_BIT(NIB_K_BIT)
  ) u_unpack (
    .mode_i (mode_w),
    .code_i (code_i),
    .fall_i (fall_q),
    .rise_i (bus_i),
    .word_o (word_w),
    .k_o    (k_w),
    .drive_o(drive_w)
  );

  // Configuration tracking and output registers (rising-edge domain)
  lane_mode_e                      cfg_mode_q, cfg_mode_d;
  logic                            cfg_code_q, cfg_code_d;
  logic                            run_q, run_d;
  logic                            cfg_same;
  logic [CH_COUNT-1:0][WORD_W-1:0] word_q, word_d;
  logic [CH_COUNT-1:0]             k_q, k_d;
  logic [CH_COUNT-1:0]             valid_q, valid_d;

  always_comb begin
    cfg_mode_d = mode_w;
    cfg_code_d = code_i;
    run_d      = 1'b1;
    cfg_same   = (mode_w == cfg_mode_q) && (code_i == cfg_code_q);
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      valid_d[ch] = run_q && cfg_same && drive_w[ch];
      word_d[ch]  = valid_d[ch] ? word_w[ch] : '0;
      k_d[ch]     = valid_d[ch] && k_w[ch];
    end
  end

  always_ff @(posedge tx_clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cfg_mode_q <= MODE_INDEP;
      cfg_code_q <= 1'b0;
      run_q      <= 1'b0;
      word_q     <= '0;
      k_q        <= '0;
      valid_q    <= '0;
    end else begin
      cfg_mode_q <= cfg_mode_d;
      cfg_code_q <= cfg_code_d;
      run_q      <= run_d;
      word_q     <= word_d;
      k_q        <= k_d;
      valid_q    <= valid_d;
    end
  end

  assign a_word_o  = word_q[0];
  assign a_k_o     = k_q[0];
  assign a_valid_o = valid_q[0];
  assign b_word_o  = word_q[1];
  assign b_k_o     = k_q[1];
  assign b_valid_o = valid_q[1];

endmodule

// File: rtl/tx_ddr_lane_demux_chk.sv
// Property checker, attached to the top through bind.
module tx_ddr_lane_demux_chk #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              code_i,
  input logic [WORD_W-1:0] a_word_i,
  input logic              a_k_i,
  input logic              a_valid_i,
  input logic [WORD_W-1:0] b_word_i,
  input logic              b_k_i,
  input logic              b_valid_i
);

  // R5: raw format never raises a K flag
  p_raw_no_k_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_i |=> (!a_k_i && !b_k_i));

  // R6, R7: byte format leaves the top word bits clear
  p_byte_pad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i |=> (a_word_i[WORD_W-1:DATA_W] == '0 && b_word_i[WORD_W-1:DATA_W] == '0));

  // R4: dedicated mode never validates channel B
  p_indep_b_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> !b_valid_i);

  // R9: a configuration change voids the next word
  p_cfg_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i) || code_i != $past(code_i)) |=> (!a_valid_i && !b_valid_i));

  // R10: reserved mode drives nothing
  p_rsvd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> (!a_valid_i && !b_valid_i));

  // R10: channel B is only valid alongside channel A
  p_b_with_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_i |-> a_valid_i);

  // R10: invalid channels show zero word and K
  p_idle_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_valid_i |-> (a_word_i == '0 && !a_k_i)) and (!b_valid_i |-> (b_word_i == '0 && !b_k_i)));

endmodule

bind tx_ddr_lane_demux tx_ddr_lane_demux_chk #(
  .WORD_W(WORD_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk_i    (tx_clk),
  .rst_ni   (rst_n_sync),
  .mode_i   (mode_i),
  .code_i   (code_i),
  .a_word_i (a_word_o),
  .a_k_i    (a_k_o),
  .a_valid_i(a_valid_o),
  .b_word_i (b_word_o),
  .b_k_i    (b_k_o),
  .b_valid_i(b_valid_o)
);

// File: tb/tx_ddr_lane_demux_tb_top.sv
module tx_ddr_lane_demux_tb_top;

  typedef struct packed {
    logic [9:0] aw;
    logic       ak;
    logic       av;
    logic [9:0] bw;
    logic       bk;
    logic       bv;
  } exp_t;

  logic       clk_common = 1'b0;
  logic       clk_pair   = 1'b1;
  logic       clk_sel;
  logic       rst_n;
  logic [1:0] mode;
  logic       code;
  logic [9:0] bus;
  logic [9:0] a_word, b_word;
  logic       a_k, a_v, b_k, b_v;

  int checks = 0;
  int fails  = 0;

  // 125 MHz shared clock; pair clock runs inverted so the wrong choice is visible (R8)
  initial forever #4 clk_common = ~clk_common;
  initial forever #4 clk_pair   = ~clk_pair;

  assign clk_sel = (mode == 2'd0) ? clk_pair : clk_common;

  tx_ddr_lane_demux dut_i (
    .clk_common_i(clk_common),
    .clk_pair_i  (clk_pair),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .code_i      (code),
    .bus_i       (bus),
    .a_word_o    (a_word),
    .a_k_o       (a_k),
    .a_valid_o   (a_v),
    .b_word_o    (b_word),
    .b_k_o       (b_k),
    .b_valid_o   (b_v)
  );

  function automatic logic [10:0] map10(logic [9:0] w, logic c);
    return c ? {2'b00, w[7:0], w[8]} : {w, 1'b0};
  endfunction

  function automatic logic [10:0] mapnib(logic [4:0] lo, logic [4:0] hi, logic c);
    return c ? {2'b00, hi[4], hi[2:0], lo[4], lo[2:0], lo[3]} : {hi, lo, 1'b0};
  endfunction

  function automatic exp_t model(logic [1:0] m, logic c, logic [9:0] f, logic [9:0] r);
    exp_t e = '0;
    logic [10:0] t;
    case (m)
      2'd0: begin
        t = map10(r, c); e.aw = t[10:1]; e.ak = t[0]; e.av = 1'b1;
      end
      2'd1: begin
        t = map10(f, c); e.aw = t[10:1]; e.ak = t[0]; e.av = 1'b1;
        t = map10(r, c); e.bw = t[10:1]; e.bk = t[0]; e.bv = 1'b1;
      end
      2'd2: begin
        t = mapnib(f[4:0], r[4:0], c); e.aw = t[10:1]; e.ak = t[0]; e.av = 1'b1;
        t = mapnib(f[9:5], r[9:5], c); e.bw = t[10:1]; e.bk = t[0]; e.bv = 1'b1;
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check_ch(string tag, string ch, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s ch %s: got word=%h k=%b v=%b, expected word=%h k=%b v=%b",
               tag, ch, got[11:2], got[1], got[0], exp[11:2], exp[1], exp[0]);
    end
  endtask

  task automatic check_both(string tag, exp_t e);
    check_ch(tag, "A", {a_word, a_k, a_v}, {e.aw, e.ak, e.av});
    check_ch(tag, "B", {b_word, b_k, b_v}, {e.bw, e.bk, e.bv});
  endtask

  // Entered just after a rising edge; returns just after the next one
  task automatic period(logic [9:0] f, logic [9:0] r, string tag, bit stale);
    exp_t e;
    bus = f;
    @(negedge clk_sel); #1;
    bus = r;
    @(posedge clk_sel); #1;
    e = stale ? exp_t'('0) : model(mode, code, f, r);
    check_both(tag, e);
  endtask

  task automatic rnd_periods(int n, string tag);
    for (int i = 0; i < n; i++) begin
      period(10'($urandom), 10'($urandom), tag, 1'b0);
    end
  endtask

  // R1: reset state and the quiet edges after release
  task automatic do_reset(logic [1:0] m, logic c);
    rst_n = 1'b0;
    #1;
    mode = m;
    code = c;
    bus  = 10'($urandom);
    repeat (2) @(posedge clk_sel);
    #1;
    check_both("R1", exp_t'('0));
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_sel); #1;
      check_both("R1", exp_t'('0));
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7319);
    rst_n = 1'b0;
    mode  = 2'd1;
    code  = 1'b0;
    bus   = '0;

    // R2, R5: interleaved raw words
    do_reset(2'd1, 1'b0);
    period(10'h3FF, 10'h000, "R2", 1'b0);
    period(10'h000, 10'h3FF, "R2", 1'b0);
    period(10'h2AA, 10'h155, "R5", 1'b0);
    rnd_periods(20, "R2");

    // R9: format flip coincides with a completed word
    code = 1'b1;
    period(10'($urandom), 10'($urandom), "R9", 1'b1);
    // R6: bit 9 ignored, bit 8 is K
    period(10'h300, 10'h100, "R6", 1'b0);
    period(10'h2FF, 10'h0FF, "R6", 1'b0);
    rnd_periods(20, "R6");

    // R9: mode change into half-word mode
    mode = 2'd2;
    period(10'($urandom), 10'($urandom), "R9", 1'b1);
    // R7: K from the low half only
    period(10'h108, 10'h108, "R7", 1'b0);
    period(10'h000, 10'h108, "R7", 1'b0);
    period(10'h3F7, 10'h3FF, "R7", 1'b0);
    rnd_periods(20, "R7");

    // R3: half-word raw
    code = 1'b0;
    period(10'($urandom), 10'($urandom), "R9", 1'b1);
    period(10'h01F, 10'h000, "R3", 1'b0);
    period(10'h001, 10'h200, "R3", 1'b0);
    rnd_periods(20, "R3");

    // R4, R8: dedicated mode on the pair clock
    do_reset(2'd0, 1'b0);
    period(10'h155, 10'h2AA, "R4", 1'b0);
    period(10'h3FF, 10'h000, "R4", 1'b0);
    rnd_periods(20, "R8");
    code = 1'b1;
    period(10'($urandom), 10'($urandom), "R9", 1'b1);
    period(10'h000, 10'h3C5, "R6", 1'b0);
    rnd_periods(10, "R4");

    // R10: reserved mode drives nothing
    do_reset(2'd3, 1'b0);
    rnd_periods(4, "R10");

    // R10: random configurations, steady valid stream
    for (int round = 0; round < 12; round++) begin
      do_reset(2'($urandom), 1'($urandom));
      rnd_periods(30, "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule